// File: doc/BRIEF.md
# Multi-Mode Checksum Engine

This block folds a stream of 32-bit words into a single 32-bit accumulator, using one of four algorithms: a 32-bit CRC, a 16-bit CRC, a wrap-around sum, or even parity. Each CRC can consume the word starting at its most significant bit or at its least significant bit. A seed value can be written into the accumulator at any time, so a new checksum run can start without a reset. Every accepted word is fully absorbed in the clock cycle that accepts it, so the input never stalls.

The value presented on the result port is derived from the stored accumulator by three optional stages: bit reversal, inversion and byte swap, always applied in that order. These stages only shape the value that is read. The stored accumulator is never changed by them, so the options can be switched on and off freely between words.

Top module: `chk_engine`

## Requirements
- R1: With algorithm code 0 (CRC-32) and the lsb-first flag clear, each accepted word updates the accumulator as a CRC with polynomial 0x04C11DB7, shifting left and consuming data bit 31 first, down to bit 0.
- R2: With algorithm code 0 and the lsb-first flag set, each accepted word updates the accumulator with the reflected polynomial 0xEDB88320, shifting right and consuming data bit 0 first, up to bit 31.
- R3: With algorithm code 1 (CRC-16), the update uses the low 16 accumulator bits, polynomial 0x1021 msb-first or reflected 0x8408 lsb-first, in the same bit orders as R1 and R2. Accumulator bits 31:16 become zero on each update.
- R4: With algorithm code 2, each accepted word is added to the accumulator modulo 2^32.
- R5: With algorithm code 3, accumulator bit 0 becomes its old value XOR the XOR of all 32 data bits, and bits 31:1 become zero.
- R6: A seed write loads seed_val into the accumulator on the next clock edge. If a data word is offered in the same cycle, the seed wins and the word is dropped.
- R7: in_ready is 1 in every cycle, including during reset.
- R8: The reverse option (cfg_rev) mirrors all 32 bits. With algorithm code 1 it mirrors only bits 15:0 and leaves bits 31:16 in place.
- R9: The invert option (cfg_inv) flips all 32 result bits.
- R10: The swap option (cfg_swap) reverses the byte order of the 32-bit result.
- R11: When several options are enabled, the result is formed by reversing first, then inverting, then swapping bytes.
- R12: Changing the configuration never changes the stored accumulator. With all options cleared, the result equals the raw accumulator.
- R13: After reset, the accumulator is 0 and the configuration is code 0, msb-first, with no options, so the result reads 0.
- R14: In a cycle with neither in_valid nor seed_wr, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Loads the configuration fields below |
| cfg_alg | input | 2 | Algorithm: 0 CRC-32, 1 CRC-16, 2 sum, 3 parity |
| cfg_lsb | input | 1 | CRC bit order: 1 = lsb-first |
| cfg_rev | input | 1 | Result option: bit reverse |
| cfg_inv | input | 1 | Result option: invert |
| cfg_swap | input | 1 | Result option: byte swap |
| seed_wr | input | 1 | Loads seed_val into the accumulator |
| seed_val | input | 32 | Seed value |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Always 1 |
| in_data | input | 32 | Data word |
| result | output | 32 | Post-processed accumulator |

## Verification
The bench builds the engine with its default parameters: a 32-bit data path and the standard 32-bit and 16-bit CRC polynomials. With these defaults the bench's own bitwise reference model can predict every update. It also reaches the corner cases: 16-bit mode with a seed whose upper half is set, sum wrap-around past 2^32, a seed and a data word offered in the same cycle, and every combination of result options applied on top of the same stored accumulator.

// File: rtl/chk_pkg.sv
// Shared types for the checksum engine.
// Assumes: accumulator is 32 bits wide.
package chk_pkg;

    typedef enum logic [1:0] {
        ALG_CRC32 = 2'd0,
        ALG_CRC16 = 2'd1,
        ALG_SUM   = 2'd2,
        ALG_PAR   = 2'd3
    } alg_e;

    typedef struct packed {
        alg_e alg;
        logic lsb_first;
        logic opt_rev;
        logic opt_inv;
        logic opt_swap;
    } cfg_t;

    localparam int ACC_W   = 32;
    localparam int NUM_CRC = 4;

endpackage

// File: rtl/chk_crc_step.sv
// One full-word CRC update: folds DATA_W data bits into a CRC_W-bit remainder.
// Assumes: POLY is given in msb-first (normal) form; the reflected form is
// derived here when LSB_FIRST is set.
module chk_crc_step #(
    parameter int          CRC_W     = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] POLY      = 32'h04C11DB7,
    parameter bit          LSB_FIRST = 1'b0
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);

    function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
        return r;
    endfunction

    localparam logic [CRC_W-1:0] P_NORM = POLY[CRC_W-1:0];
    localparam logic [CRC_W-1:0] P_REFL = mirror(P_NORM);

    generate
        if (LSB_FIRST) begin : g_refl
            // Purpose: shift right, consume data bit 0 first.
            always_comb begin
                logic [CRC_W-1:0] c;
                logic fb;
                c = crc_in;
                for (int i = 0; i < DATA_W; i++) begin
                    fb = c[0] ^ data[i];
                    c  = c >> 1;
                    if (fb) c = c ^ P_REFL;
                end
                crc_out = c;
            end
        end else begin : g_norm
            // Purpose: shift left, consume data msb first.
            always_comb begin
                logic [CRC_W-1:0] c;
                logic fb;
                c = crc_in;
                for (int i = DATA_W - 1; i >= 0; i--) begin
                    fb = c[CRC_W-1] ^ data[i];
                    c  = c << 1;
                    if (fb) c = c ^ P_NORM;
                end
                crc_out = c;
            end
        end
    endgenerate

endmodule

// File: rtl/chk_acc_next.sv
// Next-accumulator selector: computes every algorithm's update in parallel
// and picks the one named by the configuration.
// Assumes: DATA_W equals the 32-bit accumulator width.
module chk_acc_next
    import chk_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] POLY32  = 32'h04C11DB7,
    parameter logic [31:0] POLY16  = 32'h00001021
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [DATA_W-1:0] data,
    input  cfg_t              cfg,
    output logic [ACC_W-1:0]  acc_nxt
);

    // Index: bit1 = 16-bit variant, bit0 = lsb-first variant.
    logic [ACC_W-1:0] crc_res [NUM_CRC];

    generate
        for (genvar g = 0; g < NUM_CRC; g++) begin : g_crc
            localparam bit          IS16 = (g >= 2);
            localparam int          CW   = IS16 ? 16 : 32;
            localparam logic [31:0] PP   = IS16 ? POLY16 : POLY32;
            logic [CW-1:0] c_out;
            chk_crc_step #(
                .CRC_W    (CW),
                .DATA_W   (DATA_W),
                .POLY     (PP),
                .LSB_FIRST(g % 2 == 1)
            ) u_step (
                .crc_in (acc[CW-1:0]),
                .data   (data),
                .crc_out(c_out)
            );
            if (IS16) begin : g_pad
                assign crc_res[g] = {16'h0000, c_out};
            end else begin : g_full
                assign crc_res[g] = c_out;
            end
        end
    endgenerate

    // Purpose: choose the update for the active algorithm.
    always_comb begin
        unique case (cfg.alg)
            ALG_CRC32: acc_nxt = crc_res[{1'b0, cfg.lsb_first}];
            ALG_CRC16: acc_nxt = crc_res[{1'b1, cfg.lsb_first}];
            ALG_SUM:   acc_nxt = acc + ACC_W'(data);
            ALG_PAR:   acc_nxt = {{(ACC_W-1){1'b0}}, acc[0] ^ (^data)};
            default:   acc_nxt = acc;
        endcase
    end

endmodule

// File: rtl/chk_post.sv
// Result shaping: optional reverse, then invert, then byte swap.
// Assumes: purely combinational; never writes back to the accumulator.
module chk_post
    import chk_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  cfg_t             cfg,
    output logic [ACC_W-1:0] res
);

    localparam int NBYTE = ACC_W / 8;

    logic [ACC_W-1:0] rev_full, rev_sel, inv_v, swp_v;

    // Purpose: mirror the word (full, or low half in 16-bit mode).
    always_comb begin
        for (int k = 0; k < ACC_W; k++) rev_full[k] = acc[ACC_W-1-k];
        if (cfg.alg == ALG_CRC16)
            rev_sel = {acc[ACC_W-1:16], rev_full[ACC_W-1:16]};
        else
            rev_sel = rev_full;
    end

    // Purpose: apply reverse and invert stages.
    assign inv_v = (cfg.opt_rev ? rev_sel : acc) ^ {ACC_W{cfg.opt_inv}};

    generate
        for (genvar b = 0; b < NBYTE; b++) begin : g_swap
            assign swp_v[8*b +: 8] = inv_v[8*(NBYTE-1-b) +: 8];
        end
    endgenerate

    // Purpose: final byte-swap stage.
    assign res = cfg.opt_swap ? swp_v : inv_v;

endmodule

// File: rtl/chk_engine.sv
// Top: holds configuration and accumulator, accepts one word per cycle.
// Assumes: synchronous active-low reset; seed write has priority over data.
module chk_engine
    import chk_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] POLY32 = 32'h04C11DB7,
    parameter logic [31:0] POLY16 = 32'h00001021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_alg,
    input  logic              cfg_lsb,
    input  logic              cfg_rev,
    input  logic              cfg_inv,
    input  logic              cfg_swap,
    input  logic              seed_wr,
    input  logic [31:0]       seed_val,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [31:0]       result
);

    cfg_t             cfg_q;
    logic [ACC_W-1:0] acc_q, acc_nxt;

    assign in_ready = 1'b1;

    // Purpose: configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '{alg: ALG_CRC32, lsb_first: 1'b0, opt_rev: 1'b0,
                       opt_inv: 1'b0, opt_swap: 1'b0};
        else if (cfg_wr)
            cfg_q <= '{alg: alg_e'(cfg_alg), lsb_first: cfg_lsb,
                       opt_rev: cfg_rev, opt_inv: cfg_inv, opt_swap: cfg_swap};
    end

    chk_acc_next #(
        .DATA_W(DATA_W), .POLY32(POLY32), .POLY16(POLY16)
    ) u_next (
        .acc(acc_q), .data(in_data), .cfg(cfg_q), .acc_nxt(acc_nxt)
    );

    // Purpose: accumulator with seed priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (seed_wr)   acc_q <= seed_val;
        else if (in_valid)  acc_q <= acc_nxt;
    end

    chk_post u_post (.acc(acc_q), .cfg(cfg_q), .res(result));

    p_ready_high_r7: assert property (@(posedge clk) in_ready == 1'b1);

    p_seed_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_wr |=> acc_q == $past(seed_val));

    p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_wr && !in_valid) |=> $stable(acc_q));

    p_sum_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !seed_wr && cfg_q.alg == ALG_SUM)
        |=> acc_q == $past(acc_q) + ACC_W'($past(in_data)));

    p_par_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !seed_wr && cfg_q.alg == ALG_PAR) |=> acc_q[ACC_W-1:1] == '0);

    p_crc16_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !seed_wr && cfg_q.alg == ALG_CRC16) |=> acc_q[ACC_W-1:16] == '0);

    p_cfg_keeps_acc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !seed_wr && !in_valid) |=> $stable(acc_q));

    p_plain_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.opt_rev && !cfg_q.opt_inv && !cfg_q.opt_swap) |-> result == acc_q);

endmodule

// File: tb/sim_chk_engine.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module sim_chk_engine;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_lsb = 1'b0, cfg_rev = 1'b0, cfg_inv = 1'b0, cfg_swap = 1'b0;
    logic [1:0]  cfg_alg = 2'd0;
    logic        seed_wr = 1'b0, in_valid = 1'b0;
    logic [31:0] seed_val = '0, in_data = '0;
    logic        in_ready;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    // reference state
    logic [31:0] m_acc = '0;
    logic [1:0]  m_alg = 2'd0;
    logic        m_lsb = 1'b0, m_rev = 1'b0, m_inv = 1'b0, m_swp = 1'b0;

    chk_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_alg(cfg_alg),
        .cfg_lsb(cfg_lsb), .cfg_rev(cfg_rev), .cfg_inv(cfg_inv), .cfg_swap(cfg_swap),
        .seed_wr(seed_wr), .seed_val(seed_val), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .result(result)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] ref_update(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] c;
        logic [15:0] h;
        c = a;
        h = a[15:0];
        case (m_alg)
            2'd0: begin
                if (m_lsb) begin
                    for (int i = 0; i < 32; i++) begin
                        if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320; else c = c >> 1;
                    end
                end else begin
                    for (int i = 31; i >= 0; i--) begin
                        if (c[31] ^ d[i]) c = (c << 1) ^ 32'h04C11DB7; else c = c << 1;
                    end
                end
            end
            2'd1: begin
                if (m_lsb) begin
                    for (int i = 0; i < 32; i++) begin
                        if (h[0] ^ d[i]) h = (h >> 1) ^ 16'h8408; else h = h >> 1;
                    end
                end else begin
                    for (int i = 31; i >= 0; i--) begin
                        if (h[15] ^ d[i]) h = (h << 1) ^ 16'h1021; else h = h << 1;
                    end
                end
                c = {16'h0000, h};
            end
            2'd2: c = a + d;
            default: c = {31'd0, a[0] ^ (^d)};
        endcase
        return c;
    endfunction

    function automatic logic [31:0] ref_post(input logic [31:0] a);
        logic [31:0] v;
        v = a;
        if (m_rev) begin
            if (m_alg == 2'd1) for (int k = 0; k < 16; k++) v[k] = a[15-k];
            else               for (int k = 0; k < 32; k++) v[k] = a[31-k];
        end
        if (m_inv) v = ~v;
        if (m_swp) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
        return v;
    endfunction

    task automatic push(input string tag);
        exp_q.push_back(ref_post(m_acc));
        tag_q.push_back(tag);
    endtask

    task automatic set_cfg(input logic [1:0] alg, input logic lsb, input logic rv,
                           input logic iv, input logic sw, input string tag);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_alg = alg; cfg_lsb = lsb; cfg_rev = rv; cfg_inv = iv; cfg_swap = sw;
        m_alg = alg; m_lsb = lsb; m_rev = rv; m_inv = iv; m_swp = sw;
        push(tag);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_seed(input logic [31:0] s, input string tag);
        @(negedge clk);
        seed_wr = 1'b1; seed_val = s;
        m_acc = s;
        push(tag);
        @(negedge clk);
        seed_wr = 1'b0;
    endtask

    task automatic feed(input logic [31:0] d, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        m_acc = ref_update(m_acc, d);
        push(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        push(tag);
        @(negedge clk);
    endtask

    task automatic seed_and_data(input logic [31:0] s, input logic [31:0] d, input string tag);
        @(negedge clk);
        seed_wr = 1'b1; seed_val = s; in_valid = 1'b1; in_data = d;
        m_acc = s;
        push(tag);
        @(negedge clk);
        seed_wr = 1'b0; in_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares one expected item per clock edge after the drive.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, result, e);
            chk("R7 ready", {31'd0, in_ready}, 32'd1);
        end
    end

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 ready in reset", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset result", result, 32'h0);

        // R1 CRC-32 msb-first
        load_seed(32'hFFFFFFFF, "R6 seed");
        feed(32'h00000000, "R1 crc32 msb");
        feed(32'h31323334, "R1 crc32 msb");
        feed(32'hDEADBEEF, "R1 crc32 msb");
        idle("R14 hold");
        idle("R14 hold");

        // R2 CRC-32 lsb-first
        set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R12 cfg keeps acc");
        load_seed(32'hFFFFFFFF, "R6 seed");
        feed(32'h34333231, "R2 crc32 lsb");
        feed(32'h80000001, "R2 crc32 lsb");

        // R3 CRC-16 both orders, seed with upper half set
        set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R12 cfg keeps acc");
        load_seed(32'hABCDFFFF, "R6 seed upper");
        feed(32'h12345678, "R3 crc16 msb upper cleared");
        feed(32'h0000FFFF, "R3 crc16 msb");
        set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R12 cfg keeps acc");
        load_seed(32'h5555FFFF, "R6 seed");
        feed(32'hA5A5A5A5, "R3 crc16 lsb");

        // R8-R11 post-processing on a 16-bit accumulator
        set_cfg(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 rev low half");
        set_cfg(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R9 invert");
        set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R10 swap");
        set_cfg(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R11 order");
        set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R12 raw after options");

        // R4 sum wrap
        set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R12 cfg keeps acc");
        load_seed(32'hFFFFFFF0, "R6 seed");
        feed(32'h00000020, "R4 sum wrap");
        feed(32'h12345678, "R4 sum");

        // R8-R11 on a 32-bit value
        set_cfg(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R8 rev full");
        set_cfg(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, "R11 rev then inv");
        set_cfg(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R11 rev then swap");
        set_cfg(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, "R11 inv then swap");
        set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R12 raw after options");

        // R5 parity
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R12 cfg keeps acc");
        load_seed(32'hFFFF0000, "R6 seed");
        feed(32'h00000007, "R5 parity odd");
        feed(32'h00000003, "R5 parity even word");
        feed(32'h80000000, "R5 parity");

        // R6 seed wins over data
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R12 cfg keeps acc");
        seed_and_data(32'h0BADF00D, 32'h11111111, "R6 seed priority");
        feed(32'h11111111, "R1 crc32 msb after seed");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule